// File: doc/BRIEF.md
# Four-Channel PWM Timer with Emergency Break

This block generates four pulse-width outputs from one shared free-running 12-bit upcounter. Each channel holds a 12-bit duty value and runs in one of two modes picked by a per-channel mode bit. In waveform mode its output is high while the counter is below the duty value. In compare mode its output stays low, and a sticky match flag is raised when the counter reaches the duty value. Duty writes land in shadow registers and reach the comparators only when the counter wraps, so a period is never cut short or stretched by a write made in the middle of it.

An active-low emergency input can take over all four outputs. After a two-flop synchronizer, and only when the pin-enable bit is set, a low level on that input sets a sticky halt flag. While the halt flag is set, each output is forced to its bit of a programmed safe pattern. Software can set or clear the halt flag directly, so it can force the safe pattern with the pin disabled.

Software reaches the block over a plain byte-wide register port with address, write data, write strobe and combinational read data. There is no streaming data path, so the port has no valid/ready handshake. A write takes effect on the clock edge that samples the strobe.

Top module: `pwm4_brk`

## Requirements
- R1: The counter counts 0,1,…,4095 and then returns to 0, starting from 0 after reset. A channel whose mode bit is 1 (mode register at address 0x1, bit x for channel x) drives its output high exactly while the counter is below its active duty value, so a duty of 0 keeps it low.
- R2: Register map: halt control at 0x0, mode at 0x1, match status at 0x2, duty high byte of channel x at 0x8+2x, duty low byte at 0x9+2x. Every register and every output is 0 after reset. Duty registers read back the last written (shadow) value.
- R3: Reserved bits read as 0: halt control bits 7:6, duty high bits 7:4 (duty bits 11:8 sit in bits 3:0), and mode and status bits 7:4.
- R4: A duty write changes the waveform only from the first counter value 0 after the write. The old value governs the rest of the current period.
- R5: A channel with mode bit 0 keeps its output low. It sets status bit x on the clock edge at which the counter equals its active duty value, so the flag is seen when the counter shows duty+1.
- R6: Writing 1 to status bit x clears that flag, and writing 0 leaves it. If the clear and a match fall on the same edge, the flag stays set.
- R7: With pin enable (halt control bit 4) at 1, a low level on the break input sets the halt flag (bit 5) on the third rising edge after the input falls. The flag stays set after the input returns high, until software writes it to 0.
- R8: While the break input is low and enabled, a software write of 0 to the halt flag has no effect.
- R9: With pin enable at 0, the break input has no effect on the halt flag.
- R10: While the halt flag is 1, output x equals halt-control bit x (the pattern, bits 3:0) whatever the counter, duty and mode. Software can set the flag by writing bit 5 as 1, even with the pin disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe, one write per high cycle |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| brk_ni | input | 1 | Asynchronous active-low break request |
| pwm_o | output | 4 | Channel outputs |

## Verification
Two pairs of events can land on the same edge, and in both the hardware set must win over the software clear. The first pair is a write-1-to-clear of a compare flag and a counter match on that channel. The bench provokes it by starting the clear write one cycle before the counter reaches the duty value, so that the strobe is sampled on the match edge, and then requires the flag to read 1. The second pair is a software write of 0 to the halt flag while the synchronized break input is low and enabled. The bench requires the flag to stay 1 and the outputs to stay on the safe pattern.

// File: rtl/pwm4_brk_pkg.sv
package pwm4_brk_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 4;
  localparam int unsigned DW  = 8;

  localparam logic [AW-1:0] A_HALT = 4'h0;
  localparam logic [AW-1:0] A_MODE = 4'h1;
  localparam logic [AW-1:0] A_STAT = 4'h2;

  typedef struct packed {
    logic           halt;
    logic           pin_en;
    logic [NCH-1:0] pat;
  } halt_cfg_t;
endpackage

// File: rtl/pwm4_counter.sv
module pwm4_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = (cnt_o == CMAX);
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          hi_we_i,
  input  logic          lo_we_i,
  input  logic [7:0]    wdata_i,
  input  logic          wave_mode_i,
  input  logic          clr_i,
  output logic [CW-1:0] shadow_o,
  output logic [CW-1:0] active_o,
  output logic          match_o,
  output logic          wave_o
);
  localparam int unsigned HW = CW - 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
    end else begin
      if (hi_we_i) shadow_o[CW-1:8] <= wdata_i[HW-1:0];
      if (lo_we_i) shadow_o[7:0]    <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= '0;
    else if (wrap_i) active_o <= shadow_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                match_o <= 1'b0;
    else if (!wave_mode_i && cnt_i == active_o) match_o <= 1'b1;
    else if (clr_i)                             match_o <= 1'b0;
  end

  assign wave_o = wave_mode_i && (cnt_i < active_o);
endmodule

// File: rtl/pwm4_halt_ctrl.sv
module pwm4_halt_ctrl
  import pwm4_brk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output halt_cfg_t  cfg_o,
  output logic       sync_lo_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= brk_ni;
      s2_q <= s1_q;
    end
  end

  assign sync_lo_o = !s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else begin
      if (we_i) begin
        cfg_o.pin_en <= wdata_i[4];
        cfg_o.pat    <= wdata_i[NCH-1:0];
      end
      if (cfg_o.pin_en && sync_lo_o) cfg_o.halt <= 1'b1;
      else if (we_i)                 cfg_o.halt <= wdata_i[5];
    end
  end
endmodule

// File: rtl/pwm4_brk.sv
module pwm4_brk
  import pwm4_brk_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  input  logic          brk_ni,
  output logic [NCH-1:0] pwm_o
);
  localparam int unsigned SELW = $clog2(NCH);

  logic [CW-1:0]     cnt;
  logic              wrap;
  halt_cfg_t         cfg;
  logic              sync_lo;
  logic [NCH-1:0]    mode_q;
  logic [NCH-1:0]    match;
  logic [NCH-1:0]    wave;
  logic [NCH*CW-1:0] act_flat;
  logic [CW-1:0]     shadow [NCH];
  logic              halt_we, mode_we, stat_we, duty_sel;
  logic [SELW-1:0]   ch_sel;

  assign halt_we  = we_i && addr_i == A_HALT;
  assign mode_we  = we_i && addr_i == A_MODE;
  assign stat_we  = we_i && addr_i == A_STAT;
  assign duty_sel = addr_i[AW-1];
  assign ch_sel   = addr_i[SELW:1];

  pwm4_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt), .wrap_o(wrap)
  );

  pwm4_halt_ctrl u_halt (
    .clk_i(clk_i), .rst_ni(rst_ni), .brk_ni(brk_ni), .we_i(halt_we),
    .wdata_i(wdata_i), .cfg_o(cfg), .sync_lo_o(sync_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_we) mode_q <= wdata_i[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = we_i && duty_sel && ch_sel == SELW'(g);
    pwm4_channel #(.CW(CW)) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .wrap_i(wrap),
      .hi_we_i(hit && !addr_i[0]), .lo_we_i(hit && addr_i[0]),
      .wdata_i(wdata_i), .wave_mode_i(mode_q[g]),
      .clr_i(stat_we && wdata_i[g]),
      .shadow_o(shadow[g]), .active_o(act_flat[g*CW +: CW]),
      .match_o(match[g]), .wave_o(wave[g])
    );
  end

  always_comb begin
    logic [15:0] sh16;
    sh16    = 16'(shadow[ch_sel]);
    rdata_o = '0;
    if (duty_sel) begin
      rdata_o = addr_i[0] ? sh16[7:0] : sh16[15:8];
    end else begin
      case (addr_i)
        A_HALT:  rdata_o = {2'b00, cfg.halt, cfg.pin_en, cfg.pat};
        A_MODE:  rdata_o = DW'(mode_q);
        A_STAT:  rdata_o = DW'(match);
        default: rdata_o = '0;
      endcase
    end
  end

  assign pwm_o = cfg.halt ? cfg.pat : wave;
endmodule

// File: rtl/pwm4_brk_chk.sv
module pwm4_brk_chk
  import pwm4_brk_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NCH-1:0]    pwm_o,
  input logic [CW-1:0]     cnt,
  input logic [NCH*CW-1:0] act_flat,
  input logic [NCH-1:0]    mode_q,
  input logic [NCH-1:0]    match,
  input logic              sync_lo,
  input logic              halt_we,
  input halt_cfg_t         cfg
);
  localparam logic [CW-1:0] CMAX = '1;

  // R1
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == CMAX |=> cnt == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != CMAX |=> cnt == $past(cnt) + 1'b1);

  // R4
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != CMAX |=> $stable(act_flat));

  // R5
  cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q[0] && cnt == act_flat[CW-1:0]) |=> match[0]);

  // R3
  rsvd_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_HALT |-> rdata_o[7:6] == 2'b00);

  // R7
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.pin_en && sync_lo) |=> cfg.halt);

  // R9
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_we && !(cfg.pin_en && sync_lo)) |=> $stable(cfg.halt));

  // R10
  brk_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.halt |-> pwm_o == cfg.pat);
endmodule

bind pwm4_brk pwm4_brk_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .pwm_o(pwm_o), .cnt(cnt), .act_flat(act_flat), .mode_q(mode_q),
  .match(match), .sync_lo(sync_lo), .halt_we(halt_we), .cfg(cfg)
);

// File: tb/pwm4_brk_tb.sv
module pwm4_brk_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       brk_n = 1'b1;
  logic [3:0] pwm;
  logic [11:0] m = '0;
  int checks = 0;
  int fails = 0;

  pwm4_brk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .brk_ni(brk_n), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of the period counter from R1.
  always @(posedge clk) begin
    if (!rst_n) m <= '0;
    else        m <= m + 12'd1;
  end

  // {duty, probe counter value, expected output of channel 0}
  localparam logic [24:0] VEC [7] = '{
    {12'd0,    12'd0,    1'b0},
    {12'd1,    12'd0,    1'b1},
    {12'd1,    12'd1,    1'b0},
    {12'd2048, 12'd2047, 1'b1},
    {12'd2048, 12'd2048, 1'b0},
    {12'd4095, 12'd4094, 1'b1},
    {12'd4095, 12'd4095, 1'b0}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_m(input logic [11:0] v);
    while (m != v) @(negedge clk);
  endtask

  task automatic wait_load();
    wait_m(12'd4090);
    wait_m(12'd0);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    // R2 reset state
    rd(4'h0, d); chk(d, 8'h00, "R2 halt reset");
    rd(4'h1, d); chk(d, 8'h00, "R2 mode reset");
    rd(4'h9, d); chk(d, 8'h00, "R2 duty reset");
    chk(pwm, 4'h0, "R2 outputs reset");
    rst_n = 1'b1;
    cyc(2);

    // R3 reserved bits
    wr(4'h0, 8'hFF); rd(4'h0, d); chk(d, 8'h3F, "R3 halt reserved");
    wr(4'h0, 8'h00);
    wr(4'hC, 8'hFF); rd(4'hC, d); chk(d, 8'h0F, "R3 duty hi reserved");
    wr(4'hC, 8'h00);
    wr(4'h1, 8'hFF); rd(4'h1, d); chk(d, 8'h0F, "R3 mode reserved");

    // R1 waveform vectors on channel 0
    wr(4'h1, 8'h01); rd(4'h1, d); chk(d, 8'h01, "R2 mode readback");
    for (int i = 0; i < 7; i++) begin
      wr(4'h8, {4'h0, VEC[i][24:21]});
      wr(4'h9, VEC[i][20:13]);
      wait_load();
      wait_m(VEC[i][12:1]);
      chk({15'd0, pwm[0]}, {15'd0, VEC[i][0]}, "R1 waveform vector");
    end

    // R4 shadow update only at wrap
    wr(4'h8, 8'h00); wr(4'h9, 8'd100);
    wait_load();
    wait_m(12'd50);
    wr(4'h8, 8'h0B); wr(4'h9, 8'hB8);
    rd(4'h8, d); chk(d, 8'h0B, "R2 shadow readback");
    wait_m(12'd200);
    chk({15'd0, pwm[0]}, 16'd0, "R4 old duty kept");
    wait_load();
    wait_m(12'd200);
    chk({15'd0, pwm[0]}, 16'd1, "R4 new duty at wrap");

    // R5 compare on channel 1, duty 500
    wr(4'hA, 8'h01); wr(4'hB, 8'hF4);
    wait_load();
    wr(4'h2, 8'h02);
    wait_m(12'd500);
    rd(4'h2, d); chk(d & 8'h02, 8'h00, "R5 flag before match");
    wait_m(12'd501);
    rd(4'h2, d); chk(d & 8'h02, 8'h02, "R5 flag after match");
    chk({15'd0, pwm[1]}, 16'd0, "R5 compare output low");
    // R6 clear, then clear colliding with match
    wr(4'h2, 8'h00); rd(4'h2, d); chk(d & 8'h02, 8'h02, "R6 write 0 keeps");
    wr(4'h2, 8'h02); rd(4'h2, d); chk(d & 8'h02, 8'h00, "R6 w1c clears");
    wait_load();
    wait_m(12'd499);
    wr(4'h2, 8'h02);
    rd(4'h2, d); chk(d & 8'h02, 8'h02, "R6 set wins over clear");
    wr(4'h2, 8'h02); rd(4'h2, d); chk(d & 8'h02, 8'h00, "R6 clear after collision");

    // R7 synchronizer latency and stickiness
    wr(4'h0, 8'h1A);
    brk_n = 1'b0;
    cyc(2);
    rd(4'h0, d); chk(d & 8'h20, 8'h00, "R7 not yet set");
    cyc(1);
    rd(4'h0, d); chk(d, 8'h3A, "R7 set on third edge");
    chk(pwm, 4'hA, "R10 pattern forced");
    // R8 software clear while pin low
    wr(4'h0, 8'h1A);
    rd(4'h0, d); chk(d & 8'h20, 8'h20, "R8 clear ignored");
    chk(pwm, 4'hA, "R8 pattern kept");
    brk_n = 1'b1;
    cyc(4);
    rd(4'h0, d); chk(d & 8'h20, 8'h20, "R7 sticky after release");
    wr(4'h0, 8'h1A);
    rd(4'h0, d); chk(d, 8'h1A, "R7 software clear");

    // R9 pin disabled
    wr(4'h0, 8'h0A);
    brk_n = 1'b0;
    cyc(6);
    rd(4'h0, d); chk(d, 8'h0A, "R9 pin ignored");
    brk_n = 1'b1;
    cyc(4);

    // R10 software force with pin disabled
    wr(4'h0, 8'h25);
    rd(4'h0, d); chk(d, 8'h25, "R10 software halt readback");
    chk(pwm, 4'h5, "R10 software pattern");
    wr(4'h0, 8'h00);
    rd(4'h0, d); chk(d, 8'h00, "R10 halt released");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule